// File: doc/BRIEF.md
# Hash Accelerator Control and Block Loader

This block is the control front end of a hash accelerator. A 32-bit control register, written over a simple write strobe, selects the operating mode, the input source, the output handling and the byte order. Writing the register with the start bit set kicks off a new message. The block then spends one cycle initializing the digest state and afterwards collects sixteen 32-bit words into a block buffer.

Words come either from processor writes on a data port or from a DMA request/acknowledge handshake. Each word can have its four bytes reversed on the way in. When the sixteenth word is in, the block hands the buffered block to a compression core with a one-cycle start pulse. It waits for the core's done pulse, then signals completion, either as a digest interrupt for the processor or as a drain request for an output DMA. It then starts collecting the next block.

Top module: `hash_front_ctrl`

## Requirements
- R1: After reset the control readback is 0, and waiting, core_init, core_start, dma_req, digest_irq, drain_req and overrun are all 0.
- R2: A register write stores mode in bits 2:0, DMA input select in bit 8, output drain select in bit 9 and byte swap in bit 12. Every other bit, including the start bit 4, reads back as 0.
- R3: A write with bit 4 set and a hash mode (codes 1, 2 or 3) drives waiting low and core_init high for exactly one cycle. After that cycle waiting is high and the word counter is at slot 0.
- R4: A write with bit 4 set and mode 0 or 4 to 7 leaves the block idle: waiting, core_init and dma_req stay 0.
- R5: With bit 8 clear and waiting high, each din_wr stores din_data into the next slot, in order 0 to 15. Slot i appears at blk_data[32*i+31:32*i].
- R6: The cycle after the sixteenth word is stored, waiting is 0 and core_start is 1 for one cycle. Waiting stays 0 until core_done, and is 1 the cycle after core_done.
- R7: With bit 8 set, dma_req is 1 whenever waiting is 1 and stays 1 until dma_ack. Each dma_ack stores dma_data, din_wr stores nothing, and dma_req is 0 while waiting is 0.
- R8: A core_done while the core is busy gives a one-cycle digest_irq on the next cycle when bit 9 is 0. When bit 9 is 1 it gives a one-cycle drain_req instead.
- R9: With bit 12 clear a word is stored unchanged. With bit 12 set its bytes are reversed, so bits 7:0 land in bits 31:24.
- R10: A din_wr while waiting is 0 leaves the block buffer unchanged and sets the sticky overrun flag, which the next start write clears.
- R11: A start write during loading or while busy discards the partial block and restarts from slot 0. A core_done arriving after such an abort, while the core is not busy, raises neither digest_irq nor drain_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 32 | Control register write data |
| reg_rdata | output | 32 | Control register readback |
| din_wr | input | 1 | Processor input word write strobe |
| din_data | input | 32 | Processor input word |
| dma_req | output | 1 | Request for one input word from DMA |
| dma_ack | input | 1 | DMA word acknowledge, data valid |
| dma_data | input | 32 | DMA input word |
| waiting | output | 1 | Block is accepting input words |
| overrun | output | 1 | Sticky flag for writes made while not waiting |
| core_init | output | 1 | One-cycle digest initialization pulse |
| core_start | output | 1 | One-cycle compression launch pulse |
| core_done | input | 1 | Compression finished pulse |
| blk_data | output | 512 | Buffered block, slot i in bits 32*i+31:32*i |
| digest_irq | output | 1 | One-cycle digest-ready interrupt |
| drain_req | output | 1 | One-cycle output DMA drain request |

## Verification
Blocks are loaded with random words from the processor port, both back to back and with random gaps, and the results tell slot ordering apart from counter slips. The same loads run with byte swap on and off, which shows whether reversal happens per word or not at all. DMA loads use random acknowledge latencies to show that the request is held and that processor writes in that mode are discarded. Directed cases cover starting in a non-hash mode, writing during compression, aborting during loading and during compression, and a stray done pulse, which separate the idle, overrun and abort paths.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  localparam int CTRL_W      = 32;
  localparam int MODE_W      = 3;
  localparam int MODE_LSB    = 0;
  localparam int START_BIT   = 4;
  localparam int DMA_IN_BIT  = 8;
  localparam int DMA_OUT_BIT = 9;
  localparam int SWAP_BIT    = 12;

  localparam logic [MODE_W-1:0] HASH_MODE_LO = 3'd1;
  localparam logic [MODE_W-1:0] HASH_MODE_HI = 3'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_LOAD = 2'd2,
    ST_BUSY = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic              swap;
    logic              dma_out;
    logic              dma_in;
    logic [MODE_W-1:0] mode;
  } ctrl_fields_t;

  function automatic logic is_hash_mode(input logic [MODE_W-1:0] m);
    return (m >= HASH_MODE_LO) && (m <= HASH_MODE_HI);
  endfunction
endpackage

// File: rtl/hfc_ctrl_reg.sv
module hfc_ctrl_reg
  import hfc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [CTRL_W-1:0]   reg_wdata,
  output ctrl_fields_t        fields,
  output logic                start_cmd,
  output logic [MODE_W-1:0]   start_mode,
  output logic [CTRL_W-1:0]   reg_rdata
);
  ctrl_fields_t fields_q, fields_d;
  logic         fields_en;

  assign fields_en = reg_wr;

  always_comb begin
    fields_d         = fields_q;
    fields_d.mode    = reg_wdata[MODE_LSB +: MODE_W];
    fields_d.dma_in  = reg_wdata[DMA_IN_BIT];
    fields_d.dma_out = reg_wdata[DMA_OUT_BIT];
    fields_d.swap    = reg_wdata[SWAP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fields_q <= '0;
    else if (fields_en) fields_q <= fields_d;
  end

  // start is a command: decoded from the write, never stored
  assign start_cmd  = reg_wr & reg_wdata[START_BIT];
  assign start_mode = reg_wdata[MODE_LSB +: MODE_W];
  assign fields     = fields_q;

  always_comb begin
    reg_rdata                         = '0;
    reg_rdata[MODE_LSB +: MODE_W]     = fields_q.mode;
    reg_rdata[DMA_IN_BIT]             = fields_q.dma_in;
    reg_rdata[DMA_OUT_BIT]            = fields_q.dma_out;
    reg_rdata[SWAP_BIT]               = fields_q.swap;
  end

  p_field_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[MODE_LSB +: MODE_W] == $past(reg_wdata[MODE_LSB +: MODE_W]))
               && (reg_rdata[SWAP_BIT] == $past(reg_wdata[SWAP_BIT])));
endmodule

// File: rtl/hfc_byte_order.sv
module hfc_byte_order #(
  parameter int WORD_W = 32
) (
  input  logic              swap,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  localparam int NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] reversed;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign reversed[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
  end

  assign dout = swap ? reversed : din;
endmodule

// File: rtl/hfc_word_buffer.sv
module hfc_word_buffer #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    take,
  input  logic [WORD_W-1:0]       wdata,
  output logic                    last,
  output logic [DEPTH*WORD_W-1:0] blk_flat
);
  localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign last   = (cnt_q == LAST_SLOT);
  assign cnt_en = clr | take;

  always_comb begin
    if (clr)       cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic              slot_en;

    assign slot_en = take & ~clr & (cnt_q == CNT_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wdata;
    end

    assign blk_flat[s*WORD_W +: WORD_W] = slot_q;
  end

  p_slot_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_wrap_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && last) |=> (cnt_q == '0));

  p_clear_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/hfc_seq.sv
module hfc_seq
  import hfc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic [MODE_W-1:0] start_mode,
  input  logic              dma_in,
  input  logic              dma_out,
  input  logic              din_wr,
  input  logic              dma_ack,
  input  logic              core_done,
  input  logic              last,
  output logic              take,
  output logic              waiting,
  output logic              core_init,
  output logic              core_start,
  output logic              dma_req,
  output logic              digest_irq,
  output logic              drain_req,
  output logic              overrun
);
  seq_state_e state_q, state_d;
  logic       start_q, start_d;
  logic       irq_q, irq_d;
  logic       drain_q, drain_d;
  logic       ovr_q, ovr_d;
  logic       in_load, in_busy, finish;

  assign in_load = (state_q == ST_LOAD);
  assign in_busy = (state_q == ST_BUSY);

  assign take   = in_load & ~start_cmd & (dma_in ? dma_ack : din_wr);
  assign finish = in_busy & core_done & ~start_cmd;

  always_comb begin
    state_d = state_q;
    if (start_cmd) begin
      state_d = is_hash_mode(start_mode) ? ST_INIT : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_INIT: state_d = ST_LOAD;
        ST_LOAD: if (take && last) state_d = ST_BUSY;
        ST_BUSY: if (core_done)    state_d = ST_LOAD;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    start_d = take & last;
    irq_d   = finish & ~dma_out;
    drain_d = finish &  dma_out;
    if (start_cmd) ovr_d = 1'b0;
    else           ovr_d = ovr_q | (din_wr & ~in_load);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      drain_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      irq_q   <= irq_d;
      drain_q <= drain_d;
      ovr_q   <= ovr_d;
    end
  end

  assign waiting    = in_load;
  assign core_init  = (state_q == ST_INIT);
  assign core_start = start_q;
  assign dma_req    = in_load & dma_in;
  assign digest_irq = irq_q;
  assign drain_req  = drain_q;
  assign overrun    = ovr_q;

  p_init_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_init && !start_cmd) |=> (waiting && !core_init));

  p_idle_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !is_hash_mode(start_mode)) |=> (!waiting && !core_init));

  p_launch_not_waiting_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> !waiting);

  p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busy && !core_done && !start_cmd) |=> !waiting);

  p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && !start_cmd && dma_in) |=> dma_req);

  p_irq_from_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (digest_irq || drain_req) |-> $past(core_done));

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !start_cmd) |=> overrun);

  p_abort_no_launch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (!core_start && !digest_irq && !drain_req));
endmodule

// File: rtl/hash_front_ctrl.sv
module hash_front_ctrl
  import hfc_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BLK_WORDS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [CTRL_W-1:0]           reg_wdata,
  output logic [CTRL_W-1:0]           reg_rdata,
  input  logic                        din_wr,
  input  logic [WORD_W-1:0]           din_data,
  output logic                        dma_req,
  input  logic                        dma_ack,
  input  logic [WORD_W-1:0]           dma_data,
  output logic                        waiting,
  output logic                        overrun,
  output logic                        core_init,
  output logic                        core_start,
  input  logic                        core_done,
  output logic [BLK_WORDS*WORD_W-1:0] blk_data,
  output logic                        digest_irq,
  output logic                        drain_req
);
  ctrl_fields_t      fields;
  logic              start_cmd;
  logic [MODE_W-1:0] start_mode;
  logic              take, last;
  logic [WORD_W-1:0] raw_word, ordered_word;

  hfc_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .fields     (fields),
    .start_cmd  (start_cmd),
    .start_mode (start_mode),
    .reg_rdata  (reg_rdata)
  );

  hfc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_cmd  (start_cmd),
    .start_mode (start_mode),
    .dma_in     (fields.dma_in),
    .dma_out    (fields.dma_out),
    .din_wr     (din_wr),
    .dma_ack    (dma_ack),
    .core_done  (core_done),
    .last       (last),
    .take       (take),
    .waiting    (waiting),
    .core_init  (core_init),
    .core_start (core_start),
    .dma_req    (dma_req),
    .digest_irq (digest_irq),
    .drain_req  (drain_req),
    .overrun    (overrun)
  );

  assign raw_word = fields.dma_in ? dma_data : din_data;

  hfc_byte_order #(.WORD_W(WORD_W)) u_order (
    .swap (fields.swap),
    .din  (raw_word),
    .dout (ordered_word)
  );

  hfc_word_buffer #(.WORD_W(WORD_W), .DEPTH(BLK_WORDS)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_cmd),
    .take     (take),
    .wdata    (ordered_word),
    .last     (last),
    .blk_flat (blk_data)
  );

  p_buffer_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!waiting && !start_cmd) |=> $stable(blk_data));

  p_no_req_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !waiting |-> !dma_req);
endmodule

// File: tb/hash_front_ctrl_tb_top.sv
module hash_front_ctrl_tb_top;
  localparam int W = 32;
  localparam int N = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           din_wr = 1'b0;
  logic [W-1:0]   din_data = '0;
  logic           dma_req;
  logic           dma_ack = 1'b0;
  logic [W-1:0]   dma_data = '0;
  logic           waiting, overrun, core_init, core_start;
  logic           core_done = 1'b0;
  logic [N*W-1:0] blk_data;
  logic           digest_irq, drain_req;

  int errors = 0;
  int checks = 0;
  logic [W-1:0] words [N];

  always #2.5 clk = ~clk;

  hash_front_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .din_wr(din_wr), .din_data(din_data),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_data(dma_data),
    .waiting(waiting), .overrun(overrun), .core_init(core_init),
    .core_start(core_start), .core_done(core_done), .blk_data(blk_data),
    .digest_irq(digest_irq), .drain_req(drain_req)
  );

  function automatic logic [31:0] ctrl_val(input logic [2:0] mode, input logic st,
      input logic di, input logic dout, input logic sw);
    logic [31:0] v = '0;
    v[2:0] = mode; v[4] = st; v[8] = di; v[9] = dout; v[12] = sw;
    return v;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] w, input logic sw);
    return sw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
      input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic push(input logic [31:0] w);
    din_wr = 1'b1; din_data = w;
    @(negedge clk);
    din_wr = 1'b0;
  endtask

  task automatic pulse_done();
    core_done = 1'b1;
    @(negedge clk);
    core_done = 1'b0;
  endtask

  task automatic fill_words();
    for (int i = 0; i < N; i++) words[i] = $urandom;
  endtask

  task automatic check_block(input logic sw, input string req);
    logic ok = 1'b1;
    logic [31:0] a = '0, e = '0;
    for (int i = 0; i < N; i++) begin
      if (blk_data[i*W +: W] !== exp_word(words[i], sw) && ok) begin
        ok = 1'b0; a = blk_data[i*W +: W]; e = exp_word(words[i], sw);
      end
    end
    check(ok, req, {32'd0, a}, {32'd0, e});
  endtask

  // processor load of one block with optional random gaps
  task automatic cpu_block(input logic gaps);
    for (int i = 0; i < N; i++) begin
      push(words[i]);
      if (gaps && i != N-1) repeat ($urandom_range(0, 2)) @(negedge clk);
    end
  endtask

  task automatic dma_block();
    int taken = 0;
    logic held_ok = 1'b1;
    while (taken < N) begin
      if (!dma_req) held_ok = 1'b0;
      if ($urandom_range(0, 2) == 0) begin
        dma_ack = 1'b1; dma_data = words[taken]; taken++;
        din_wr = 1'b1; din_data = 32'hDEAD_BEEF;
      end else begin
        dma_ack = 1'b0; din_wr = 1'b0;
      end
      @(negedge clk);
      dma_ack = 1'b0; din_wr = 1'b0;
    end
    check(held_ok, "R7 dma_req held while block open", {63'd0, held_ok}, 64'd1);
  endtask

  task automatic finish_block(input logic sw, input logic dout, input string req);
    check(core_start && !waiting, "R6 core_start after 16th word",
          {62'd0, core_start, waiting}, 64'd2);
    check_block(sw, req);
    @(negedge clk);
    check(!core_start && !waiting, "R6 single launch, waiting low",
          {62'd0, core_start, waiting}, 64'd0);
    repeat ($urandom_range(1, 4)) @(negedge clk);
    check(!waiting && !dma_req, "R6 R7 stays low until done",
          {62'd0, waiting, dma_req}, 64'd0);
    pulse_done();
    check(waiting && (digest_irq == !dout) && (drain_req == dout),
          "R8 completion signal", {61'd0, waiting, digest_irq, drain_req},
          {61'd0, 1'b1, !dout, dout});
    @(negedge clk);
    check(!digest_irq && !drain_req, "R8 completion one cycle",
          {62'd0, digest_irq, drain_req}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*W-1:0] snap;
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 0 && !waiting && !core_init && !core_start && !dma_req
          && !digest_irq && !drain_req && !overrun, "R1 reset state",
          {32'd0, reg_rdata}, 64'd0);

    // R2 and R4: all ones, mode 7 with start: idle, readback masked
    wr_ctrl(32'hFFFF_FFFF);
    check(reg_rdata == 32'h0000_1307, "R2 readback mask", {32'd0, reg_rdata},
          64'h1307);
    check(!waiting && !core_init && !dma_req, "R4 mode 7 idle",
          {61'd0, waiting, core_init, dma_req}, 64'd0);
    wr_ctrl(ctrl_val(3'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    repeat (2) @(negedge clk);
    check(!waiting && !core_init, "R4 mode 0 idle",
          {62'd0, waiting, core_init}, 64'd0);
    wr_ctrl(ctrl_val(3'd5, 1'b1, 1'b1, 1'b0, 1'b0));
    check(!waiting && !core_init && !dma_req, "R4 mode 5 idle",
          {61'd0, waiting, core_init, dma_req}, 64'd0);

    // R3 start SHA-256 code, processor loading, no swap
    wr_ctrl(ctrl_val(3'd2, 1'b1, 1'b0, 1'b0, 1'b0));
    check(!waiting && core_init, "R3 init cycle", {62'd0, waiting, core_init}, 64'd1);
    check(reg_rdata == 32'h2, "R2 start bit reads 0", {32'd0, reg_rdata}, 64'h2);
    @(negedge clk);
    check(waiting && !core_init, "R3 waiting after init",
          {62'd0, waiting, core_init}, 64'd2);
    fill_words();
    cpu_block(1'b0);
    // R10: write during busy is ignored and flagged
    snap = blk_data;
    push(32'h1234_5678);
    check(blk_data == snap, "R10 buffer unchanged", {32'd0, blk_data[31:0]},
          {32'd0, snap[31:0]});
    check(overrun, "R10 overrun set", {63'd0, overrun}, 64'd1);
    // back in sequence: pretend launch already seen; finish with direct checks
    repeat (2) @(negedge clk);
    pulse_done();
    check(waiting && digest_irq, "R8 irq with bit 9 clear",
          {62'd0, waiting, digest_irq}, 64'd3);
    @(negedge clk);
    check(overrun, "R10 overrun sticky", {63'd0, overrun}, 64'd1);

    // R5 R9 fresh start, swap on, mode 1, random gaps
    wr_ctrl(ctrl_val(3'd1, 1'b1, 1'b0, 1'b0, 1'b1));
    check(!overrun, "R10 overrun cleared by start", {63'd0, overrun}, 64'd0);
    @(negedge clk);
    fill_words();
    cpu_block(1'b1);
    finish_block(1'b1, 1'b0, "R5 R9 swapped block");

    // second block in same message, no swap toggled via rewrite without start
    wr_ctrl(ctrl_val(3'd1, 1'b0, 1'b0, 1'b0, 1'b0));
    check(waiting, "R2 plain write keeps state", {63'd0, waiting}, 64'd1);
    fill_words();
    cpu_block(1'b0);
    finish_block(1'b0, 1'b0, "R5 R9 unswapped block");

    // R7 DMA loading with drain select, a few random blocks
    wr_ctrl(ctrl_val(3'd3, 1'b1, 1'b1, 1'b1, 1'b0));
    check(!dma_req, "R7 no request in init", {63'd0, dma_req}, 64'd0);
    @(negedge clk);
    for (int b = 0; b < 3; b++) begin
      check(dma_req && waiting, "R7 request while waiting",
            {62'd0, dma_req, waiting}, 64'd3);
      fill_words();
      dma_block();
      finish_block(1'b0, 1'b1, "R7 dma block content");
    end

    // R11 abort during loading
    wr_ctrl(ctrl_val(3'd2, 1'b1, 1'b0, 1'b0, 1'b1));
    @(negedge clk);
    for (int i = 0; i < 5; i++) push($urandom);
    wr_ctrl(ctrl_val(3'd2, 1'b1, 1'b0, 1'b0, 1'b1));
    check(!waiting && core_init, "R11 abort reinitializes",
          {62'd0, waiting, core_init}, 64'd1);
    @(negedge clk);
    fill_words();
    for (int i = 0; i < N-5; i++) push(words[i]);
    check(waiting && !core_start, "R11 counter restarted at slot 0",
          {62'd0, waiting, core_start}, 64'd2);
    for (int i = N-5; i < N; i++) push(words[i]);
    check_block(1'b1, "R11 block after abort");

    // R11 abort while busy, then stray done ignored
    wr_ctrl(ctrl_val(3'd2, 1'b1, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check(waiting, "R11 abort from busy reloads", {63'd0, waiting}, 64'd1);
    pulse_done();
    check(!digest_irq && !drain_req && waiting, "R11 stray done ignored",
          {61'd0, digest_irq, drain_req, waiting}, 64'd1);
    fill_words();
    cpu_block(1'b1);
    finish_block(1'b0, 1'b0, "R5 block after busy abort");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule